// File: doc/BRIEF.md
# User-Level Counter Access Gate

This block decides how a least-privileged (level-0) access to a performance counter, or to one of that counter's control bits, is to be treated. A per-counter access mask selects which counters user code may touch. A user-enable control and the general and per-class read controls then settle what kind of access is allowed. The block returns one of four verdicts: legacy handling, read-as-zero/write-ignored, read-only, or read/write. The counter datapath and any exception generation stay outside the block.

The mask holds one bit per event counter at that counter's index, then one bit for the cycle counter and one for the instruction counter. The mask takes effect only when the user-enable control is effectively set. When it does not take effect, the block answers with the legacy verdict and the coarse controls decide elsewhere. The verdict covers the counter value and its associated controls together: the enable set/clear bits, the overflow set/clear bits, and the counter's bit in the zeroing register. The decision logic is combinational. A parameter places a register after it.

Top module: `pmu_user_gate`

## Requirements
- R1: When level 1 is in 32-bit state, when the user-enable control is 0, or when the access has already raised an exception, the verdict is legacy, whatever the mask holds.
- R2: The verdict `res_o` is encoded as 2'b00 legacy, 2'b01 read-as-zero/write-ignored, 2'b10 read-only, 2'b11 read/write.
- R3: The counter class `cls_i` is encoded as 2'b00 event, 2'b01 cycle, 2'b10 instruction. Class 2'b11 gives read-as-zero/write-ignored unless R1 applies.
- R4: Mask bit i (i below NUM_EVT) belongs to event counter i. Bit NUM_EVT (31 by default) belongs to the cycle counter, and bit NUM_EVT+1 (32) to the instruction counter. When the selected bit is 0 and R1 does not apply, the verdict is read-as-zero/write-ignored. This one verdict covers the counter, its enable/overflow set and clear bits, and its zeroing-register bit.
- R5: An event index at or above `n_acc_i`, or at or above NUM_EVT, behaves as if its mask bit were 0.
- R6: For an event or cycle counter whose mask bit is 1, `gen_en_i`=1 gives read/write. Otherwise the class read control decides: `evt_rd_i` for events, `cyc_rd_i` for the cycle counter. A value of 1 gives read-only and a value of 0 gives read-as-zero/write-ignored. Each class ignores the other class's read control.
- R7: For the instruction counter with its mask bit 1, `ins_rd_i`=1 gives read-only and `ins_rd_i`=0 gives read/write. `gen_en_i` has no effect on this class.
- R8: A write (`wr_i`=1) that would get the read-only verdict gets read-as-zero/write-ignored instead. A read gets read-only and returns the live value.
- R9: With REG_OUT=1, `res_o` reflects the inputs present at the previous rising clock edge. While `rst_ni` is low, `res_o` is legacy (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acr_mask_i | input | NUM_EVT+2 | Per-counter user access mask |
| usr_en_i | input | 1 | Effective user-enable control |
| gen_en_i | input | 1 | General user read/write enable |
| evt_rd_i | input | 1 | Read control for event counters |
| cyc_rd_i | input | 1 | Read control for the cycle counter |
| ins_rd_i | input | 1 | Read control for the instruction counter |
| el1_a32_i | input | 1 | Level 1 is in 32-bit state |
| exc_i | input | 1 | Access has already raised an exception |
| cls_i | input | 2 | Counter class |
| idx_i | input | $clog2(NUM_EVT) | Event counter index |
| n_acc_i | input | $clog2(NUM_EVT+1) | Number of event counters accessible |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| res_o | output | 2 | Access verdict |

## Verification
The hardest case to reach is an event access whose mask bit is set but whose index lies at or beyond the accessible count. This is most telling at the exact boundary where the index equals `n_acc_i`, and at index 31, which has no event counter at all. The stimulus fills the mask with ones, steps `n_acc_i` across the index so that only the range check can refuse access, then sweeps every index against a one-hot mask. The bypass conditions are applied with every mask bit and control set, so that a bypass that leaks shows up as a non-legacy verdict.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;
  typedef enum logic [1:0] {
    RES_LEGACY = 2'b00,
    RES_RAZWI  = 2'b01,
    RES_RO     = 2'b10,
    RES_RW     = 2'b11
  } gate_res_e;

  typedef enum logic [1:0] {
    CLS_EVT = 2'b00,
    CLS_CYC = 2'b01,
    CLS_INS = 2'b10,
    CLS_RSV = 2'b11
  } ctr_cls_e;

  typedef struct packed {
    logic gen_en;
    logic evt_rd;
    logic cyc_rd;
    logic ins_rd;
  } user_ctl_t;
endpackage

// File: rtl/pmu_gate_bitsel.sv
module pmu_gate_bitsel
  import pmu_gate_pkg::*;
#(
  parameter int NUM_EVT = 31,
  localparam int MASK_W = NUM_EVT + 2,
  localparam int IDX_W  = $clog2(NUM_EVT),
  localparam int CNT_W  = $clog2(NUM_EVT + 1),
  localparam int CYC_POS = NUM_EVT,
  localparam int INS_POS = NUM_EVT + 1
) (
  input  logic [MASK_W-1:0] mask_i,
  input  ctr_cls_e          cls_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CNT_W-1:0]  n_acc_i,
  output logic              bit_o
);
  logic [NUM_EVT-1:0] evt_ok;
  logic               evt_bit;

  // an event bit counts only below the accessible limit
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    assign evt_ok[g] = mask_i[g] && (CNT_W'(g) < n_acc_i);
  end

  always_comb begin
    evt_bit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (idx_i == IDX_W'(i)) evt_bit = evt_ok[i];
    end
  end

  always_comb begin
    unique case (cls_i)
      CLS_EVT: bit_o = evt_bit;
      CLS_CYC: bit_o = mask_i[CYC_POS];
      CLS_INS: bit_o = mask_i[INS_POS];
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmu_gate_mode.sv
module pmu_gate_mode
  import pmu_gate_pkg::*;
(
  input  logic      usr_en_i,
  input  logic      el1_a32_i,
  input  logic      exc_i,
  input  ctr_cls_e  cls_i,
  input  logic      bit_i,
  input  user_ctl_t ctl_i,
  input  logic      wr_i,
  output gate_res_e res_o
);
  gate_res_e ro_res;

  assign ro_res = wr_i ? RES_RAZWI : RES_RO;

  always_comb begin
    if (el1_a32_i || !usr_en_i || exc_i) begin
      res_o = RES_LEGACY;
    end else if (!bit_i) begin
      res_o = RES_RAZWI;
    end else begin
      unique case (cls_i)
        CLS_EVT: res_o = ctl_i.gen_en ? RES_RW : (ctl_i.evt_rd ? ro_res : RES_RAZWI);
        CLS_CYC: res_o = ctl_i.gen_en ? RES_RW : (ctl_i.cyc_rd ? ro_res : RES_RAZWI);
        CLS_INS: res_o = ctl_i.ins_rd ? ro_res : RES_RW;
        default: res_o = RES_RAZWI;
      endcase
    end
  end
endmodule

// File: rtl/pmu_gate_oreg.sv
module pmu_gate_oreg
  import pmu_gate_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  gate_res_e d_i,
  output gate_res_e q_o
);
  if (REG_OUT) begin : g_reg
    gate_res_e q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RES_LEGACY;
      else         q <= d_i;
    end
    assign q_o = q;
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/pmu_user_gate.sv
module pmu_user_gate
  import pmu_gate_pkg::*;
#(
  parameter int NUM_EVT = 31,
  parameter bit REG_OUT = 1'b1,
  localparam int MASK_W = NUM_EVT + 2,
  localparam int IDX_W  = $clog2(NUM_EVT),
  localparam int CNT_W  = $clog2(NUM_EVT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MASK_W-1:0] acr_mask_i,
  input  logic              usr_en_i,
  input  logic              gen_en_i,
  input  logic              evt_rd_i,
  input  logic              cyc_rd_i,
  input  logic              ins_rd_i,
  input  logic              el1_a32_i,
  input  logic              exc_i,
  input  logic [1:0]        cls_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CNT_W-1:0]  n_acc_i,
  input  logic              wr_i,
  output logic [1:0]        res_o
);
  ctr_cls_e  cls;
  user_ctl_t ctl;
  logic      sel_bit;
  gate_res_e res_d;
  gate_res_e res_q;

  assign cls = ctr_cls_e'(cls_i);
  assign ctl = '{gen_en: gen_en_i, evt_rd: evt_rd_i, cyc_rd: cyc_rd_i, ins_rd: ins_rd_i};

  pmu_gate_bitsel #(.NUM_EVT(NUM_EVT)) u_bitsel (
    .mask_i  (acr_mask_i),
    .cls_i   (cls),
    .idx_i   (idx_i),
    .n_acc_i (n_acc_i),
    .bit_o   (sel_bit)
  );

  pmu_gate_mode u_mode (
    .usr_en_i  (usr_en_i),
    .el1_a32_i (el1_a32_i),
    .exc_i     (exc_i),
    .cls_i     (cls),
    .bit_i     (sel_bit),
    .ctl_i     (ctl),
    .wr_i      (wr_i),
    .res_o     (res_d)
  );

  pmu_gate_oreg #(.REG_OUT(REG_OUT)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (res_d),
    .q_o    (res_q)
  );

  assign res_o = res_q;
endmodule

// File: rtl/pmu_user_gate_chk.sv
module pmu_user_gate_chk #(
  parameter int NUM_EVT = 31,
  parameter bit REG_OUT = 1'b1,
  localparam int MASK_W = NUM_EVT + 2,
  localparam int IDX_W  = $clog2(NUM_EVT),
  localparam int CNT_W  = $clog2(NUM_EVT + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MASK_W-1:0] acr_mask_i,
  input logic              usr_en_i,
  input logic              ins_rd_i,
  input logic              el1_a32_i,
  input logic              exc_i,
  input logic [1:0]        cls_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [CNT_W-1:0]  n_acc_i,
  input logic              wr_i,
  input logic [1:0]        res_o
);
  logic              primed_q;
  logic [MASK_W-1:0] mask_q;
  logic              uen_q, ird_q, a32_q, exc_q, wr_q;
  logic [1:0]        cls_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  nacc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      mask_q <= '0; uen_q <= 1'b0; ird_q <= 1'b0; a32_q <= 1'b0; exc_q <= 1'b0;
      wr_q <= 1'b0; cls_q <= '0; idx_q <= '0; nacc_q <= '0;
    end else begin
      primed_q <= 1'b1;
      mask_q <= acr_mask_i; uen_q <= usr_en_i; ird_q <= ins_rd_i; a32_q <= el1_a32_i;
      exc_q <= exc_i; wr_q <= wr_i; cls_q <= cls_i; idx_q <= idx_i; nacc_q <= n_acc_i;
    end
  end

  logic              ok, v_uen, v_ird, v_a32, v_exc, v_wr, bypass;
  logic [MASK_W-1:0] v_mask;
  logic [1:0]        v_cls;
  logic [IDX_W-1:0]  v_idx;
  logic [CNT_W-1:0]  v_nacc;

  assign ok     = REG_OUT ? primed_q : 1'b1;
  assign v_mask = REG_OUT ? mask_q : acr_mask_i;
  assign v_uen  = REG_OUT ? uen_q  : usr_en_i;
  assign v_ird  = REG_OUT ? ird_q  : ins_rd_i;
  assign v_a32  = REG_OUT ? a32_q  : el1_a32_i;
  assign v_exc  = REG_OUT ? exc_q  : exc_i;
  assign v_wr   = REG_OUT ? wr_q   : wr_i;
  assign v_cls  = REG_OUT ? cls_q  : cls_i;
  assign v_idx  = REG_OUT ? idx_q  : idx_i;
  assign v_nacc = REG_OUT ? nacc_q : n_acc_i;
  assign bypass = v_a32 || !v_uen || v_exc;

  p_legacy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && bypass |-> res_o == 2'b00);
  p_no_legacy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && !bypass |-> res_o != 2'b00);
  p_rsv_cls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && !bypass && v_cls == 2'b11 |-> res_o == 2'b01);
  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && !bypass && v_cls == 2'b00 && ({1'b0, v_idx} >= {1'b0, v_nacc}) |-> res_o == 2'b01);
  p_ins_rw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && !bypass && v_cls == 2'b10 && v_mask[NUM_EVT+1] && !v_ird |-> res_o == 2'b11);
  p_wr_not_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok && v_wr |-> res_o != 2'b10);
endmodule

bind pmu_user_gate pmu_user_gate_chk #(.NUM_EVT(NUM_EVT), .REG_OUT(REG_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acr_mask_i (acr_mask_i),
  .usr_en_i   (usr_en_i),
  .ins_rd_i   (ins_rd_i),
  .el1_a32_i  (el1_a32_i),
  .exc_i      (exc_i),
  .cls_i      (cls_i),
  .idx_i      (idx_i),
  .n_acc_i    (n_acc_i),
  .wr_i       (wr_i),
  .res_o      (res_o)
);

// File: tb/pmu_user_gate_test.sv
module pmu_user_gate_test;
  localparam int NE = 31;
  localparam int MW = NE + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [MW-1:0] mask;
  logic          uen, gen, erd, crd, ird, a32, exc, wr;
  logic [1:0]    cls;
  logic [4:0]    idx, nacc;
  logic [1:0]    res;

  // staged stimulus, copied to the pins at a falling edge
  logic [MW-1:0] s_mask;
  logic          s_uen, s_gen, s_erd, s_crd, s_ird, s_a32, s_exc, s_wr;
  logic [1:0]    s_cls;
  logic [4:0]    s_idx, s_nacc;

  typedef struct {
    logic [1:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmu_user_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .acr_mask_i(mask), .usr_en_i(uen), .gen_en_i(gen),
    .evt_rd_i(erd), .cyc_rd_i(crd), .ins_rd_i(ird), .el1_a32_i(a32), .exc_i(exc),
    .cls_i(cls), .idx_i(idx), .n_acc_i(nacc), .wr_i(wr), .res_o(res)
  );

  function automatic logic [1:0] model();
    logic b;
    if (s_a32 || !s_uen || s_exc) return 2'b00;
    case (s_cls)
      2'b00:   b = (s_idx < NE) && (s_idx < s_nacc) && s_mask[s_idx];
      2'b01:   b = s_mask[NE];
      2'b10:   b = s_mask[NE+1];
      default: b = 1'b0;
    endcase
    if (!b) return 2'b01;
    if (s_cls == 2'b10) return s_ird ? (s_wr ? 2'b01 : 2'b10) : 2'b11;
    if (s_gen) return 2'b11;
    if ((s_cls == 2'b00) ? s_erd : s_crd) return s_wr ? 2'b01 : 2'b10;
    return 2'b01;
  endfunction

  task automatic base();
    s_mask = '1; s_uen = 1; s_gen = 0; s_erd = 0; s_crd = 0; s_ird = 0;
    s_a32 = 0; s_exc = 0; s_wr = 0; s_cls = 2'b00; s_idx = 0; s_nacc = 5'd31;
  endtask

  task automatic apply(input string req);
    item_t it;
    @(negedge clk);
    mask = s_mask; uen = s_uen; gen = s_gen; erd = s_erd; crd = s_crd; ird = s_ird;
    a32 = s_a32; exc = s_exc; wr = s_wr; cls = s_cls; idx = s_idx; nacc = s_nacc;
    it.exp = model();
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: output registered at the edge after the drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (res !== it.exp) begin
          fails++;
          $display("FAIL %s: res_o=%b expected=%b", it.req, res, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    base();
    mask = s_mask; uen = 1; gen = 1; erd = 1; crd = 1; ird = 1;
    a32 = 0; exc = 0; wr = 0; cls = 0; idx = 0; nacc = 5'd31;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (res !== 2'b00) begin
      fails++;
      $display("FAIL R9: reset res_o=%b expected=00", res);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 bypass conditions, mask all ones
    base(); s_gen = 1; s_uen = 0; apply("R1 usr_en=0");
    base(); s_gen = 1; s_a32 = 1; apply("R1 el1 32-bit");
    base(); s_gen = 1; s_exc = 1; apply("R1 exception");
    base(); s_mask = '0; s_uen = 0; apply("R1 mask ignored");
    base(); s_cls = 2'b10; s_exc = 1; apply("R1 ins exception");
    // R2 encodings all observed
    base(); s_gen = 1; apply("R2 rw code");
    base(); s_erd = 1; apply("R2 ro code");
    // R3 reserved class
    base(); s_gen = 1; s_erd = 1; s_crd = 1; s_ird = 1; s_cls = 2'b11; apply("R3 class 11");
    base(); s_gen = 1; s_cls = 2'b01; apply("R3 cycle class");
    // R4 bit positions
    base(); s_gen = 1; s_mask[5] = 0; s_idx = 5; apply("R4 event bit 0");
    base(); s_gen = 1; s_mask[NE] = 0; s_cls = 2'b01; apply("R4 cycle bit 0");
    base(); s_mask[NE+1] = 0; s_cls = 2'b10; apply("R4 ins bit 0");
    base(); s_gen = 1; s_mask = '0; s_mask[NE] = 1; s_cls = 2'b01; apply("R4 only cycle bit");
    base(); s_mask = '0; s_mask[NE+1] = 1; s_cls = 2'b10; apply("R4 only ins bit");
    base(); s_gen = 1; s_mask = '0; s_mask[NE] = 1; s_idx = 0; apply("R4 cycle bit not event");
    // R5 accessible range
    base(); s_gen = 1; s_idx = 10; s_nacc = 10; apply("R5 idx==n_acc");
    base(); s_gen = 1; s_idx = 10; s_nacc = 11; apply("R5 idx<n_acc");
    base(); s_gen = 1; s_idx = 31; s_nacc = 31; apply("R5 idx 31");
    base(); s_gen = 1; s_idx = 0; s_nacc = 0; apply("R5 n_acc 0");
    // R6 class read selectors
    base(); s_erd = 1; apply("R6 event ro");
    base(); s_crd = 1; apply("R6 event ignores cyc_rd");
    base(); s_crd = 1; s_cls = 2'b01; apply("R6 cycle ro");
    base(); s_erd = 1; s_cls = 2'b01; apply("R6 cycle ignores evt_rd");
    // R7 instruction class
    base(); s_gen = 1; s_ird = 1; s_cls = 2'b10; apply("R7 ins ro with gen");
    base(); s_cls = 2'b10; apply("R7 ins rw no gen");
    // R8 writes
    base(); s_erd = 1; s_wr = 1; apply("R8 event ro write");
    base(); s_crd = 1; s_wr = 1; s_cls = 2'b01; apply("R8 cycle ro write");
    base(); s_ird = 1; s_wr = 1; s_cls = 2'b10; apply("R8 ins ro write");
    base(); s_gen = 1; s_wr = 1; apply("R8 rw write");
    // R4 R5 sweep: one-hot mask, index across the range
    for (int i = 0; i < 32; i++) begin
      base(); s_gen = 1; s_nacc = 5'd20; s_mask = '0; s_mask[i % NE] = 1'b1; s_idx = 5'(i);
      apply("R5 sweep");
      s_idx = 5'((i + 1) % 32); apply("R4 sweep neighbour");
    end
    // R9 back-to-back changes each cycle
    base(); s_gen = 1; apply("R9 b2b a");
    base(); s_uen = 0; apply("R9 b2b b");
    base(); s_erd = 1; apply("R9 b2b c");

    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule